// File: doc/BRIEF.md
# Processor Reset Sequencer

This block takes a 32-bit processor core out of reset. It watches three kinds of reset cause: a power-on reset, an active-low reset pin from the board, and a set of internal reset requests from other logic on the chip. Each asynchronous source goes through a two-stage synchronizer. A request only turns into master reset at a bus-cycle boundary, so a write that the core has started always completes. Any work under way at that point is dropped. After power-on, master reset stays asserted until the clock synthesizer reports lock, and then for a fixed number of further cycles. If lock is lost during that count, the count starts again.

While master reset is asserted, the block supplies the values the core loads into its status and vector-base registers. When master reset is released, the block runs a fixed sequence. First it captures the breakpoint input. Then it reads two long words from the boot region over a request/acknowledge read port: the first becomes the supervisor stack pointer and the second becomes the program counter. Finally it reads the word at the new program counter and pulses a start-decode strobe. The core is held stalled from reset until that last read is acknowledged.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `por_n` is released, `mst_rst` stays high while `pll_locked` is low. Once lock is stable, `mst_rst` stays high for at least POR_CYCLES (default 512) cycles after `pll_locked` rises, and falls no more than 8 cycles after that.
- R2: If `pll_locked` drops during the power-on count, the count restarts. The full POR_CYCLES window is measured from the next rise of `pll_locked`.
- R3: A reset request (`ext_rst_n` low, or any bit of `int_rst_req` high) passes through two synchronizer flops. With the bus idle, `mst_rst` is still low one cycle after the request is applied and is high three cycles after it.
- R4: A request seen while `bus_busy` is high does not assert `mst_rst`. A request pulse that ends while `bus_busy` is still high is remembered. `mst_rst` rises on the first clock edge at which `bus_busy` is low.
- R5: While `mst_rst` is high, `sr_value` has bits 15 and 14 (trace) at 0, bit 13 (supervisor) at 1 and bits 10:8 (interrupt mask) at 7, which gives 0x2700. `vbr_value` is 0. While `mst_rst` is low, `sr_value` is 0.
- R6: `brk_flag` holds the level of `brk_in` captured in the cycle after `mst_rst` falls, before the first read request. Later changes of `brk_in` do not affect it.
- R7: After release, the block reads byte address BOOT_BASE and then BOOT_BASE+4. The first data word goes to `ssp` and the second to `pc`.
- R8: After the vector reads, one read is issued at address `pc[ADDR_W-1:0]`. Its data goes to `first_word`. `decode_start` pulses for exactly one cycle, in the cycle after that read is acknowledged.
- R9: `core_stall` is high from reset until the first-instruction read is acknowledged, and low from the cycle in which `decode_start` pulses.
- R10: `rd_req` is held high, with `rd_addr` unchanged, until a cycle with `rd_ack` high completes the transfer.
- R11: A request that arrives while a read waits for `rd_ack` takes effect only once that read is acknowledged. `rd_req` is low while `mst_rst` is high, and the release sequence then restarts from the BOOT_BASE read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pll_locked | input | 1 | Clock synthesizer lock indication, asynchronous |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| int_rst_req | input | N_INT | Internal reset requests, active high, asynchronous |
| bus_busy | input | 1 | Core has a bus cycle in progress |
| brk_in | input | 1 | Breakpoint input, captured on release |
| mst_rst | output | 1 | Master reset to the core |
| sr_value | output | 16 | Status register value to load while `mst_rst` is high |
| vbr_value | output | ADDR_W | Vector base value to load while `mst_rst` is high |
| brk_flag | output | 1 | Captured breakpoint level |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data | input | DATA_W | Read data |
| ssp | output | DATA_W | Loaded supervisor stack pointer |
| pc | output | DATA_W | Loaded program counter |
| first_word | output | DATA_W | Data of the first-instruction read |
| decode_start | output | 1 | One-cycle strobe that starts decoding |
| core_stall | output | 1 | Holds the core stalled during reset and vector fetch |

## Verification
The release sequence is run many times, each time triggered by a randomly chosen source: the board pin or one of the internal request bits. Some runs have the core bus idle and some have it busy. Idle runs pin down the exact two-flop latency. Busy runs, with short request pulses, show that a pending request is held back and remembered until the bus-cycle boundary. Each run uses fresh memory contents, random acknowledge delays and a random breakpoint level that is flipped once reads begin. This tells the stack-pointer, program-counter and first-word loads apart, and shows that the breakpoint capture happens before any bus activity. Directed cases cover a loss of lock partway through the power-on count and a reset that arrives while a vector read is stalled.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR    = 3'd0,   // power-on wait (lock + count)
        ST_HOLD   = 3'd1,   // master reset held while a request persists
        ST_BKPT   = 3'd2,   // capture breakpoint level
        ST_VEC_SP = 3'd3,   // read first vector long word
        ST_VEC_PC = 3'd4,   // read second vector long word
        ST_FETCH  = 3'd5,   // read at the new program counter
        ST_RUN    = 3'd6    // core released
    } seq_state_e;

    // Status register field positions decoded by the core
    localparam int SR_T1_BIT  = 15;
    localparam int SR_T0_BIT  = 14;
    localparam int SR_S_BIT   = 13;
    localparam int SR_IPM_LSB = 8;
    localparam logic [2:0] IPM_ALL_MASKED = 3'd7;

    localparam logic [15:0] SR_TRACE_BITS =
        (16'h1 << SR_T1_BIT) | (16'h1 << SR_T0_BIT);
    localparam logic [15:0] SR_RESET_VAL =
        ((16'h1 << SR_S_BIT) | (16'(IPM_ALL_MASKED) << SR_IPM_LSB)) & ~SR_TRACE_BITS;

    function automatic logic st_in_reset(seq_state_e s);
        return (s == ST_POR) || (s == ST_HOLD);
    endfunction

    function automatic logic st_on_bus(seq_state_e s);
        return (s == ST_VEC_SP) || (s == ST_VEC_PC) || (s == ST_FETCH);
    endfunction

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [1:0] stg_d;
        logic [1:0] stg_q;

        always_comb begin
            stg_d = {stg_q[0], async_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= 2'b00;
            end else begin
                stg_q <= stg_d;
            end
        end

        assign sync_out[g] = stg_q[1];
    end

endmodule

// File: rtl/por_timer.sv
`timescale 1ns/1ps
module por_timer #(
    parameter int POR_CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    output logic done
);

    localparam int CNT_W = $clog2(POR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } por_t;

    por_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!cur_q.done) begin
            if (!lock_s) begin
                nxt_d.cnt = '0;                    // lock lost: start over
            end else if (cur_q.cnt == CNT_LAST) begin
                nxt_d.done = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cnt: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done = cur_q.done;

endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          DATA_W     = 32,
    parameter int          N_INT      = 2,
    parameter int          POR_CYCLES = 512,
    parameter int unsigned BOOT_BASE  = 0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pll_locked,
    input  logic              ext_rst_n,
    input  logic [N_INT-1:0]  int_rst_req,
    input  logic              bus_busy,
    input  logic              brk_in,
    output logic              mst_rst,
    output logic [15:0]       sr_value,
    output logic [ADDR_W-1:0] vbr_value,
    output logic              brk_flag,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ssp,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] first_word,
    output logic              decode_start,
    output logic              core_stall
);

    localparam int SYNC_W   = N_INT + 2;
    localparam int LOCK_IDX = N_INT + 1;
    localparam logic [ADDR_W-1:0] VEC_SP_ADDR = ADDR_W'(BOOT_BASE);
    localparam logic [ADDR_W-1:0] VEC_PC_ADDR = ADDR_W'(BOOT_BASE + 4);

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic              brk;
        logic [DATA_W-1:0] ssp;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] word;
        logic              dec;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_POR, pend: 1'b0, brk: 1'b0,
                                 ssp: '0, pc: '0, word: '0, dec: 1'b0};

    seq_t cur_q, nxt_d;

    logic [SYNC_W-1:0] raw_w;
    logic [SYNC_W-1:0] sync_w;
    logic              req_any;
    logic              lock_s;
    logic              por_done;
    logic              busy_rd;
    logic              mid_xfer;
    logic              accept;

    // Synchronize every asynchronous cause, plus the lock indication
    assign raw_w = {pll_locked, int_rst_req, ~ext_rst_n};

    rst_sync #(.WIDTH(SYNC_W)) i_rst_sync (
        .clk      (clk),
        .rst_n    (por_n),
        .async_in (raw_w),
        .sync_out (sync_w)
    );

    assign req_any = |sync_w[N_INT:0];
    assign lock_s  = sync_w[LOCK_IDX];

    por_timer #(.POR_CYCLES(POR_CYCLES)) i_por_timer (
        .clk    (clk),
        .rst_n  (por_n),
        .lock_s (lock_s),
        .done   (por_done)
    );

    assign busy_rd  = st_on_bus(cur_q.st);
    assign mid_xfer = busy_rd && !rd_ack;
    // A request is taken only between bus cycles: the core's own and ours
    assign accept   = !st_in_reset(cur_q.st) && (cur_q.pend || req_any)
                      && !bus_busy && !mid_xfer;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.dec = 1'b0;

        if (st_in_reset(cur_q.st)) begin
            nxt_d.pend = 1'b0;
        end else begin
            nxt_d.pend = cur_q.pend || req_any;
        end

        unique case (cur_q.st)
            ST_POR: begin
                if (por_done) nxt_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (!req_any) nxt_d.st = ST_BKPT;
            end
            ST_BKPT: begin
                nxt_d.brk = brk_in;
                nxt_d.st  = ST_VEC_SP;
            end
            ST_VEC_SP: begin
                if (rd_ack) begin
                    nxt_d.ssp = rd_data;
                    nxt_d.st  = ST_VEC_PC;
                end
            end
            ST_VEC_PC: begin
                if (rd_ack) begin
                    nxt_d.pc = rd_data;
                    nxt_d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_ack) begin
                    nxt_d.word = rd_data;
                    nxt_d.dec  = 1'b1;
                    nxt_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                nxt_d.st = ST_RUN;
            end
            default: begin
                nxt_d.st = ST_HOLD;
            end
        endcase

        // Abort whatever is under way
        if (accept) begin
            nxt_d.st   = ST_HOLD;
            nxt_d.pend = 1'b0;
            nxt_d.dec  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cur_q <= SEQ_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        unique case (cur_q.st)
            ST_VEC_SP: rd_addr = VEC_SP_ADDR;
            ST_VEC_PC: rd_addr = VEC_PC_ADDR;
            ST_FETCH:  rd_addr = cur_q.pc[ADDR_W-1:0];
            default:   rd_addr = '0;
        endcase
    end

    assign mst_rst      = st_in_reset(cur_q.st);
    assign sr_value     = mst_rst ? SR_RESET_VAL : 16'h0000;
    assign vbr_value    = '0;
    assign brk_flag     = cur_q.brk;
    assign rd_req       = busy_rd;
    assign ssp          = cur_q.ssp;
    assign pc           = cur_q.pc;
    assign first_word   = cur_q.word;
    assign decode_start = cur_q.dec;
    assign core_stall   = (cur_q.st != ST_RUN);

endmodule

// File: rtl/rst_seq_chk.sv
`timescale 1ns/1ps
module rst_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_busy,
    input logic              mst_rst,
    input logic [15:0]       sr_value,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              decode_start,
    input logic              core_stall
);

    AST_SR_FIELDS: assert property (@(posedge clk) disable iff (!por_n)
        mst_rst |-> (sr_value[15:14] == 2'b00) && sr_value[13] && (sr_value[10:8] == 3'd7)); // R5

    AST_RST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mst_rst) |-> !$past(bus_busy)); // R4

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R10

    AST_NO_RD_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
        mst_rst |-> !rd_req); // R11

    AST_STALL_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
        mst_rst |-> core_stall); // R9

    AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        decode_start |=> !decode_start); // R8

    AST_DEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!por_n)
        decode_start |-> $past(rd_req && rd_ack)); // R8

    AST_DEC_FREES_CORE: assert property (@(posedge clk) disable iff (!por_n)
        decode_start |-> !core_stall); // R9

endmodule

bind rst_seq_ctrl rst_seq_chk #(.ADDR_W(ADDR_W)) i_rst_seq_chk (
    .clk          (clk),
    .por_n        (por_n),
    .bus_busy     (bus_busy),
    .mst_rst      (mst_rst),
    .sr_value     (sr_value),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_ack       (rd_ack),
    .decode_start (decode_start),
    .core_stall   (core_stall)
);

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;

    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int N_INT      = 2;
    localparam int POR_CYCLES = 512;

    logic              clk;
    logic              por_n;
    logic              pll_locked;
    logic              ext_rst_n;
    logic [N_INT-1:0]  int_rst_req;
    logic              bus_busy;
    logic              brk_in;
    logic              mst_rst;
    logic [15:0]       sr_value;
    logic [ADDR_W-1:0] vbr_value;
    logic              brk_flag;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ssp;
    logic [DATA_W-1:0] pc;
    logic [DATA_W-1:0] first_word;
    logic              decode_start;
    logic              core_stall;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    // responder state
    logic              hold_ack;
    int unsigned       ack_wait;
    logic [ADDR_W-1:0] xlog [0:7];
    int                xcnt;
    logic [31:0]       salt;

    rst_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_INT(N_INT), .POR_CYCLES(POR_CYCLES)
    ) i_rst_seq_ctrl (
        .clk(clk), .por_n(por_n), .pll_locked(pll_locked), .ext_rst_n(ext_rst_n),
        .int_rst_req(int_rst_req), .bus_busy(bus_busy), .brk_in(brk_in),
        .mst_rst(mst_rst), .sr_value(sr_value), .vbr_value(vbr_value),
        .brk_flag(brk_flag), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .ssp(ssp), .pc(pc), .first_word(first_word),
        .decode_start(decode_start), .core_stall(core_stall)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h0001_9E37 + 32'h1357_2468) ^ salt;
    endfunction

    // Read responder with random acknowledge delay
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req && !hold_ack) begin
            if (ack_wait == 0) begin
                rd_ack  = 1'b1;
                rd_data = mem_word(rd_addr);
                if (xcnt < 8) xlog[xcnt] = rd_addr;
                xcnt     = xcnt + 1;
                ack_wait = $urandom_range(0, 3);
            end else begin
                ack_wait = ack_wait - 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Waits for release, checks the whole boot sequence
    task automatic release_boot(input logic exp_brk, output int waited);
        int n;
        logic [31:0] exp_pc;
        waited = 0;
        while (mst_rst && waited < 40) begin tick(1); waited++; end
        chk("R5 sr_value after release", 32'(sr_value), 32'h0);
        n = 0;
        while (!rd_req && n < 40) begin tick(1); n++; end
        @(negedge clk) brk_in = ~exp_brk;      // late change must not matter
        n = 0;
        while (!decode_start && n < 400) begin tick(1); n++; end
        exp_pc = mem_word(ADDR_W'(4));
        chk("R8 decode_start pulse", 32'(decode_start), 32'h1);
        chk("R9 core_stall released", 32'(core_stall), 32'h0);
        chk("R7 transfer count", 32'(xcnt), 32'd3);
        chk("R7 first vector addr", 32'(xlog[0]), 32'h0);
        chk("R7 second vector addr", 32'(xlog[1]), 32'h4);
        chk("R7 ssp", ssp, mem_word(ADDR_W'(0)));
        chk("R7 pc", pc, exp_pc);
        chk("R8 fetch addr", 32'(xlog[2]), 32'(exp_pc[ADDR_W-1:0]));
        chk("R8 first_word", first_word, mem_word(exp_pc[ADDR_W-1:0]));
        chk("R6 brk_flag", 32'(brk_flag), 32'(exp_brk));
        tick(1);
        chk("R8 decode_start single", 32'(decode_start), 32'h0);
        chk("R9 core_stall stays low", 32'(core_stall), 32'h0);
    endtask

    task automatic set_req(input int src, input logic on);
        if (src == 0) ext_rst_n = ~on;
        else int_rst_req[src-1] = on;
    endtask

    initial begin
        int waited;
        void'($urandom(32'd20240611));
        por_n = 1'b0; pll_locked = 1'b0; ext_rst_n = 1'b1; int_rst_req = '0;
        bus_busy = 1'b0; brk_in = 1'b0; rd_ack = 1'b0; rd_data = '0;
        hold_ack = 1'b0; ack_wait = 0; xcnt = 0; salt = $urandom;

        tick(3);
        chk("R1 reset mst_rst", 32'(mst_rst), 32'h1);
        chk("R11 reset rd_req", 32'(rd_req), 32'h0);
        chk("R9 reset core_stall", 32'(core_stall), 32'h1);
        chk("R5 reset sr_value", 32'(sr_value), 32'h2700);
        chk("R5 reset vbr_value", 32'(vbr_value), 32'h0);

        @(negedge clk) por_n = 1'b1;
        tick(40);
        chk("R1 held without lock", 32'(mst_rst), 32'h1);

        // R2: lose lock partway through the count
        @(negedge clk) pll_locked = 1'b1;
        tick(300);
        @(negedge clk) pll_locked = 1'b0;
        tick(6);
        @(negedge clk) begin pll_locked = 1'b1; brk_in = 1'b1; end
        tick(POR_CYCLES);
        chk("R2 count restarted after lock loss", 32'(mst_rst), 32'h1);
        release_boot(1'b1, waited);
        chk("R1 release latency", 32'(waited <= 8), 32'h1);

        // Random sources, with and without a busy bus
        for (int it = 0; it < 24; it++) begin
            int src;
            int busy;
            int len;
            logic eb;
            src  = $urandom_range(0, N_INT);
            busy = $urandom_range(0, 1);
            len  = $urandom_range(1, 4);
            eb   = 1'($urandom_range(0, 1));
            tick(2);
            if (busy != 0) begin
                @(negedge clk) begin brk_in = eb; bus_busy = 1'b1; set_req(src, 1'b1); end
                repeat (len) @(negedge clk);
                set_req(src, 1'b0);
                tick(8);
                chk("R4 blocked while busy", 32'(mst_rst), 32'h0);
                @(negedge clk) bus_busy = 1'b0;
                tick(1);
                chk("R4 taken at boundary", 32'(mst_rst), 32'h1);
            end else begin
                @(negedge clk) begin brk_in = eb; set_req(src, 1'b1); end
                tick(1);
                chk("R3 not yet through sync", 32'(mst_rst), 32'h0);
                tick(2);
                chk("R3 through sync", 32'(mst_rst), 32'h1);
                @(negedge clk) set_req(src, 1'b0);
            end
            chk("R5 sr_value in reset", 32'(sr_value), 32'h2700);
            chk("R9 core_stall in reset", 32'(core_stall), 32'h1);
            xcnt = 0;
            salt = $urandom;
            release_boot(eb, waited);
        end

        // R11: reset while a vector read waits for acknowledge
        tick(2);
        @(negedge clk) ext_rst_n = 1'b0;
        tick(3);
        chk("R3 directed sync", 32'(mst_rst), 32'h1);
        hold_ack = 1'b1; ack_wait = 0; xcnt = 0; salt = $urandom;
        @(negedge clk) ext_rst_n = 1'b1;
        begin
            int n;
            n = 0;
            while (!rd_req && n < 40) begin tick(1); n++; end
        end
        tick(4);
        chk("R10 request held", 32'(rd_req), 32'h1);
        chk("R10 address held", 32'(rd_addr), 32'h0);
        @(negedge clk) ext_rst_n = 1'b0;
        tick(8);
        chk("R11 waits for ack", 32'(mst_rst), 32'h0);
        chk("R11 read still pending", 32'(rd_req), 32'h1);
        @(negedge clk) hold_ack = 1'b0;
        begin
            int n;
            n = 0;
            while (!mst_rst && n < 20) begin tick(1); n++; end
        end
        chk("R11 reset after ack", 32'(mst_rst), 32'h1);
        chk("R11 no read in reset", 32'(rd_req), 32'h0);
        @(negedge clk) begin
            xcnt = 0;
            salt = $urandom;
            brk_in = 1'b0;
            ext_rst_n = 1'b1;
        end
        release_boot(1'b0, waited);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule